// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a single-ported synchronous static memory with a two-bit burst address counter built in. A word is 36 bits wide, split into four 9-bit byte lanes, and each lane has its own write select. On every rising clock edge the block captures the address, the chip selects, the write controls and the write data. Read data is not registered on the way out. It comes straight from the array, so the word for a cycle is on `dout` after that cycle's clock edge and before the next one.

An access starts when one of two active-low address strobes is sampled low while the chip is selected. The processor strobe always starts a read. The controller strobe starts either a read or a write, depending on the write controls sampled on the same edge. After that, the advance input walks the counter through the other three beats of a four-beat burst. A static order pin chooses between linear order and interleaved order. The output-enable and sleep pins act combinationally on the drive flag.

The data path has no back-pressure. The block accepts inputs on every edge and presents the read word every cycle, so the interface has no valid/ready handshake. `dout_en` is the drive enable of the data outputs, standing in for a tri-state buffer.

Top module: `sync_burst_sram`

## Requirements
- R1: Flow-through read. After an edge that loads a read, `dout` shows the word at the captured address in that same cycle, and `dout_en` is 1 while `out_en_n` is 0 and `sleep` is 0.
- R2: On an edge with no strobe during an active burst, `advance_n` low steps the beat count by one. With `advance_n` high, the beat count and the base address are held.
- R3: With `burst_linear`=1, the low two address bits of beat k are (start + k) mod 4. The upper address bits stay fixed.
- R4: With `burst_linear`=0, the low two address bits of beat k are start XOR k.
- R5: After the fourth beat, a further advance wraps back to the first beat's address.
- R6: An access loads only when a strobe is low while `ce_n`, `cs_a_n` and `cs_b_n` are all low. If `proc_strobe_n` is low, it wins over `ctrl_strobe_n`. Outside a strobe edge, the selects are not looked at.
- R7: An edge that loads through `proc_strobe_n` never writes, whatever the write controls are. A write can be supplied on any following burst edge.
- R8: An edge that loads through `ctrl_strobe_n` with an active write writes `din` at the captured address. Later burst edges with an active write write at the stepped address.
- R9: Lane mask: `wr_all_n`=0 writes all four lanes. Otherwise, if `lane_wr_en_n`=0, a lane i is written when `lane_sel_n[i]`=0. Lane i is bits [9i+8:9i]. If neither condition holds, nothing is written.
- R10: `advance_n` is ignored on an edge that loads a new address, so the first beat always uses the captured address.
- R11: `out_en_n`=1 clears `dout_en` at once, without waiting for a clock edge.
- R12: `sleep`=1 clears `dout_en` at once. A strobe on an edge where `sleep` is 1 is not accepted, and any open burst is ended.
- R13: After an edge where a strobe is low but the chip is not selected, `dout_en` is 0 from the next cycle on. `dout_en` is also 0 in the cycle after a write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state (not of the array) |
| addr | input | ADDR_W | Word address, captured on a strobe edge |
| ce_n | input | 1 | Chip enable, active low |
| cs_a_n | input | 1 | First chip select, active low |
| cs_b_n | input | 1 | Second chip select, active low |
| proc_strobe_n | input | 1 | Processor address strobe, starts a read |
| ctrl_strobe_n | input | 1 | Controller address strobe, starts a read or a write |
| advance_n | input | 1 | Burst advance, active low |
| burst_linear | input | 1 | Static order select: 1 linear, 0 interleaved |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n | input | 1 | Enables the per-lane selects, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| din | input | LANES*LANE_W | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down, active high |
| dout | output | LANES*LANE_W | Flow-through read data |
| dout_en | output | 1 | Drive enable for `dout` |

## Verification
Two things can fall in the same cycle. One is a burst edge that both steps the counter and writes. The other is a combinational mute (`out_en_n` or `sleep`) arriving while a read burst is open, and a strobe can also collide with a stepping burst. Directed phases provoke each of these on purpose. A random phase then mixes strobes, advances, deselects, lane masks, output enable and sleep on every edge. A behavioural reference model keeps its own word array and its own burst position. It judges `dout_en` on every cycle, and `dout` whenever the output should be driven, sampling halfway between edges.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_SLEEP,
    OP_DESEL,
    OP_PROC_LOAD,
    OP_CTRL_LOAD,
    OP_BURST
  } sbs_op_e;

  // low two address bits for a given beat of a burst
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       linear);
    logic [1:0] r;
    if (linear) r = start + beat;
    else        r = start ^ beat;
    return r;
  endfunction

endpackage

// File: rtl/sbs_ctrl.sv
`timescale 1ns/1ps
module sbs_ctrl #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             cs_a_n,
  input  logic             cs_b_n,
  input  logic             proc_strobe_n,
  input  logic             ctrl_strobe_n,
  input  logic             advance_n,
  input  logic             wr_all_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             sleep,
  output logic             load,
  output logic             step,
  output logic [LANES-1:0] lane_we,
  output logic             drive
);
  import sbs_pkg::*;

  logic             selected, strobe_any, active;
  logic [LANES-1:0] lane_mask;
  sbs_op_e          op;

  assign selected   = !ce_n && !cs_a_n && !cs_b_n;
  assign strobe_any = !proc_strobe_n || !ctrl_strobe_n;

  // per-lane write qualification
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_mask[i] = !wr_all_n || (!lane_wr_en_n && !lane_sel_n[i]);
  end

  always_comb begin
    if (sleep)                          op = OP_SLEEP;
    else if (strobe_any && !selected)   op = OP_DESEL;
    else if (!proc_strobe_n)            op = OP_PROC_LOAD;
    else if (!ctrl_strobe_n)            op = OP_CTRL_LOAD;
    else if (active)                    op = OP_BURST;
    else                                op = OP_IDLE;
  end

  assign load    = (op == OP_PROC_LOAD) || (op == OP_CTRL_LOAD);
  assign step    = (op == OP_BURST) && !advance_n;
  assign lane_we = ((op == OP_CTRL_LOAD) || (op == OP_BURST)) ? lane_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      drive  <= 1'b0;
    end else begin
      unique case (op)
        OP_SLEEP, OP_DESEL: begin
          active <= 1'b0;
          drive  <= 1'b0;
        end
        OP_PROC_LOAD: begin
          active <= 1'b1;
          drive  <= 1'b1;
        end
        OP_CTRL_LOAD, OP_BURST: begin
          active <= 1'b1;
          drive  <= ~|lane_we;
        end
        default: begin
          active <= active;
          drive  <= 1'b0;
        end
      endcase
    end
  end

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_any && !selected && !sleep) |=> (!drive && !active)) else $error("deselect"); // R13
  AST_PROC_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strobe_n && selected && !sleep) |-> (lane_we == '0)) else $error("proc write"); // R7
  AST_SLEEP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!active && !drive)) else $error("sleep"); // R12
  AST_WRITE_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_we) |=> !drive) else $error("write drive"); // R13
  AST_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_all_n && ((!ctrl_strobe_n && proc_strobe_n && selected && !sleep) ||
                   (active && !strobe_any && !sleep))) |-> (&lane_we)) else $error("gw"); // R9
endmodule

// File: rtl/sbs_burst_ctr.sv
`timescale 1ns/1ps
module sbs_burst_ctr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              linear,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] next_addr
);
  import sbs_pkg::*;

  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base, base_d;
  logic [1:0]        beat, beat_d;

  always_comb begin
    if (load) begin
      base_d = addr_in;
      beat_d = 2'd0;      // advance is not looked at on a load edge
    end else begin
      base_d = base;
      beat_d = step ? beat + 2'd1 : beat;
    end
  end

  assign next_addr = {base_d[ADDR_W-1 -: HI_W], beat_low(base_d[1:0], beat_d, linear)};
  assign cur_addr  = {base[ADDR_W-1 -: HI_W],   beat_low(base[1:0],   beat,   linear)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
      beat <= 2'd0;
    end else begin
      base <= base_d;
      beat <= beat_d;
    end
  end

  AST_LOAD_BEAT0: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (beat == 2'd0 && base == $past(addr_in))) else $error("load"); // R10
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (beat == $past(beat) + 2'd1)) else $error("step"); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> ($stable(beat) && $stable(base))) else $error("hold"); // R2
endmodule

// File: rtl/sbs_array.sv
`timescale 1ns/1ps
module sbs_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[i]) store[waddr] <= wdata[i*LANE_W +: LANE_W];
    end

    assign rdata[i*LANE_W +: LANE_W] = store[raddr];
  end
endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ce_n,
  input  logic                    cs_a_n,
  input  logic                    cs_b_n,
  input  logic                    proc_strobe_n,
  input  logic                    ctrl_strobe_n,
  input  logic                    advance_n,
  input  logic                    burst_linear,
  input  logic                    wr_all_n,
  input  logic                    lane_wr_en_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    out_en_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  logic              load, step, drive;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] cur_addr, next_addr;

  sbs_ctrl #(.LANES(LANES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
    .advance_n(advance_n), .wr_all_n(wr_all_n), .lane_wr_en_n(lane_wr_en_n),
    .lane_sel_n(lane_sel_n), .sleep(sleep),
    .load(load), .step(step), .lane_we(lane_we), .drive(drive)
  );

  sbs_burst_ctr #(.ADDR_W(ADDR_W)) ctr_i (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .linear(burst_linear),
    .addr_in(addr), .cur_addr(cur_addr), .next_addr(next_addr)
  );

  sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
    .clk(clk), .lane_we(lane_we), .waddr(next_addr), .wdata(din),
    .raddr(cur_addr), .rdata(dout)
  );

  // combinational mute: output enable and sleep act without a clock
  assign dout_en = drive && !out_en_n && !sleep;

  AST_WRITE_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !ctrl_strobe_n && proc_strobe_n) |-> (next_addr == addr)) else $error("waddr"); // R8
endmodule

// File: tb/sync_burst_sram_tb_top.sv
`timescale 1ns/1ps
module sync_burst_sram_tb_top;
  localparam int AW = 8;
  localparam int NW = 1 << AW;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ce_n = 1'b1, cs_a_n = 1'b1, cs_b_n = 1'b1;
  logic          proc_strobe_n = 1'b1, ctrl_strobe_n = 1'b1, advance_n = 1'b1;
  logic          burst_linear = 1'b1, wr_all_n = 1'b1, lane_wr_en_n = 1'b1;
  logic [3:0]    lane_sel_n = 4'hF;
  logic [DW-1:0] din = '0;
  logic          out_en_n = 1'b0, sleep = 1'b0;
  logic [DW-1:0] dout;
  logic          dout_en;

  always #2 clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW), .LANES(4), .LANE_W(9)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n), .advance_n(advance_n),
    .burst_linear(burst_linear), .wr_all_n(wr_all_n), .lane_wr_en_n(lane_wr_en_n),
    .lane_sel_n(lane_sel_n), .din(din), .out_en_n(out_en_n), .sleep(sleep),
    .dout(dout), .dout_en(dout_en)
  );

  int    vectors = 0, fails = 0;
  string tag = "R1";

  // reference model state
  logic [DW-1:0] mem_m [NW];
  int  m_base = 0, m_beat = 0;
  bit  m_act = 0, m_drv = 0;

  function automatic int burst_addr(int base, int beat, bit lin);
    int low;
    if (lin) low = ((base & 3) + beat) & 3;
    else     low = (base & 3) ^ beat;
    return (base & ~3) | low;
  endfunction

  function automatic logic [DW-1:0] pat(int i);
    return {4'(i), 32'(i * 32'h0101_0101) ^ 32'hA5A5_0000};
  endfunction

  task automatic model_write(int a);
    logic [3:0] m;
    if (!wr_all_n)          m = 4'hF;
    else if (!lane_wr_en_n) m = ~lane_sel_n;
    else                    m = 4'h0;
    for (int k = 0; k < 4; k++)
      if (m[k]) mem_m[a][k*9 +: 9] = din[k*9 +: 9];
    m_drv = (m == 4'h0);
  endtask

  always @(posedge clk) begin
    bit sel, strb;
    if (!rst_n) begin
      m_act = 0; m_drv = 0; m_beat = 0; m_base = 0;
    end else begin
      sel  = !ce_n && !cs_a_n && !cs_b_n;
      strb = !proc_strobe_n || !ctrl_strobe_n;
      if (sleep || (strb && !sel)) begin
        m_act = 0; m_drv = 0;
      end else if (!proc_strobe_n) begin
        m_base = int'(addr); m_beat = 0; m_act = 1; m_drv = 1;
      end else if (!ctrl_strobe_n) begin
        m_base = int'(addr); m_beat = 0; m_act = 1;
        model_write(m_base);
      end else if (m_act) begin
        if (!advance_n) m_beat = (m_beat + 1) % 4;
        model_write(burst_addr(m_base, m_beat, burst_linear));
      end else begin
        m_drv = 0;
      end
    end
  end

  task automatic check(string req, logic got_en, logic exp_en, logic [DW-1:0] got, logic [DW-1:0] exp);
    vectors++;
    if (got_en !== exp_en) begin
      fails++;
      $display("FAIL %s dout_en got %0b exp %0b at %0t", req, got_en, exp_en, $time);
    end else if (exp_en && got !== exp) begin
      fails++;
      $display("FAIL %s dout got %h exp %h at %0t", req, got, exp, $time);
    end
  endtask

  // compared every cycle halfway between edges
  always @(negedge clk) begin
    if (rst_n) begin
      logic e;
      e = m_drv && !out_en_n && !sleep;
      check(tag, dout_en, e, dout, mem_m[burst_addr(m_base, m_beat, burst_linear)]);
    end
  end

  task automatic go();
    @(negedge clk); #1;
  endtask

  task automatic quiet();
    ce_n = 1'b0; cs_a_n = 1'b0; cs_b_n = 1'b0;
    proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; advance_n = 1'b1;
    wr_all_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = 4'hF;
  endtask

  task automatic proc_read(int a, bit adv);
    go(); quiet(); addr = AW'(a); proc_strobe_n = 1'b0; advance_n = !adv;
  endtask

  task automatic adv_beat(bit adv);
    go(); quiet(); advance_n = !adv;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    go(); rst_n = 1'b1;
    #1 check("R1", dout_en, 1'b0, dout, '0);

    // fill the whole array with single global writes (R8, R9)
    tag = "R8";
    for (int i = 0; i < NW; i++) begin
      go(); quiet(); addr = AW'(i); ctrl_strobe_n = 1'b0; wr_all_n = 1'b0; din = pat(i);
    end
    for (int i = 0; i < NW; i++) mem_m[i] = pat(i);

    // R1/R3/R5: linear burst from low bits 2, then wrap
    tag = "R3"; burst_linear = 1'b1;
    proc_read(8'h12, 0);
    go(); quiet();
    #0.5 check("R1", dout_en, 1'b1, dout, pat(8'h12));
    advance_n = 1'b0;
    go(); check("R3", dout_en, 1'b1, dout, pat(8'h13)); quiet(); advance_n = 1'b0;
    go(); check("R3", dout_en, 1'b1, dout, pat(8'h10)); quiet(); advance_n = 1'b0;
    go(); check("R3", dout_en, 1'b1, dout, pat(8'h11)); quiet(); advance_n = 1'b0;
    go(); check("R5", dout_en, 1'b1, dout, pat(8'h12)); quiet();

    // R4: interleaved from low bits 1 -> 1,0,3,2
    tag = "R4"; burst_linear = 1'b0;
    proc_read(8'h21, 0);
    adv_beat(1); #0.5 check("R4", dout_en, 1'b1, dout, pat(8'h21));
    adv_beat(1); #0.5 check("R4", dout_en, 1'b1, dout, pat(8'h20));
    adv_beat(1); #0.5 check("R4", dout_en, 1'b1, dout, pat(8'h23));
    adv_beat(0); #0.5 check("R4", dout_en, 1'b1, dout, pat(8'h22));

    // R2: advance held high keeps the beat
    tag = "R2";
    adv_beat(0); adv_beat(1); adv_beat(0); adv_beat(0); adv_beat(1);

    // R10: advance low on a load edge is ignored
    tag = "R10"; burst_linear = 1'b1;
    proc_read(8'h31, 1);
    adv_beat(0); #0.5 check("R10", dout_en, 1'b1, dout, pat(8'h31));

    // R7/R9: processor strobe with write controls does not write; lane writes later
    tag = "R7";
    proc_read(8'h40, 0); wr_all_n = 1'b0; din = 36'h1_2345_6789;
    go(); quiet(); advance_n = 1'b0; lane_wr_en_n = 1'b0; lane_sel_n = 4'b1010; din = 36'hF_FFFF_FFFF;
    go(); quiet();
    tag = "R9";
    proc_read(8'h40, 0);
    adv_beat(1); #0.5 check("R7", dout_en, 1'b1, dout, pat(8'h40));
    adv_beat(0); #0.5 check("R9", dout_en, 1'b1, dout, mem_m[8'h41]);
    // byte-write enable high: lane selects have no effect -> read
    go(); quiet(); addr = 8'h50; ctrl_strobe_n = 1'b0; lane_sel_n = 4'h0; din = '0;
    adv_beat(0); #0.5 check("R9", dout_en, 1'b1, dout, pat(8'h50));

    // R8: controller burst write with advance, then read back
    tag = "R8";
    go(); quiet(); addr = 8'h62; ctrl_strobe_n = 1'b0; wr_all_n = 1'b0; din = 36'hA_0000_0001;
    for (int b = 1; b < 4; b++) begin
      go(); quiet(); advance_n = 1'b0; wr_all_n = 1'b0; din = 36'hA_0000_0000 | 36'(b + 1);
    end
    proc_read(8'h60, 0);
    adv_beat(0); #0.5 check("R8", dout_en, 1'b1, dout, 36'hA_0000_0003);

    // R6/R13: deselect via strobe with a select high; ce_n without strobe is ignored
    tag = "R6";
    proc_read(8'h70, 0);
    go(); quiet(); ce_n = 1'b1; advance_n = 1'b0;
    go(); check("R6", dout_en, 1'b1, dout, pat(8'h71)); quiet();
    tag = "R13";
    cs_b_n = 1'b1; ctrl_strobe_n = 1'b0; addr = 8'h80;
    go(); check("R13", dout_en, 1'b0, dout, '0); quiet(); advance_n = 1'b0;
    go(); check("R13", dout_en, 1'b0, dout, '0); quiet();

    // R11: output enable mutes immediately
    tag = "R11";
    proc_read(8'h90, 0);
    go(); quiet(); out_en_n = 1'b1;
    #0.5 check("R11", dout_en, 1'b0, dout, '0);
    go(); out_en_n = 1'b0;
    #0.5 check("R11", dout_en, 1'b1, dout, pat(8'h90));

    // R12: sleep mutes at once, refuses a strobe and ends the burst
    tag = "R12";
    go(); quiet(); sleep = 1'b1; proc_strobe_n = 1'b0; addr = 8'hA0;
    #0.5 check("R12", dout_en, 1'b0, dout, '0);
    go(); quiet(); sleep = 1'b0; advance_n = 1'b0;
    go(); check("R12", dout_en, 1'b0, dout, '0); quiet();

    // mixed random phase, order pin fixed per half
    tag = "R2";
    for (int n = 0; n < 1200; n++) begin
      go();
      if (n == 600) burst_linear = ~burst_linear;
      addr          = AW'($urandom);
      ce_n          = ($urandom % 10) == 0;
      cs_a_n        = ($urandom % 12) == 0;
      cs_b_n        = ($urandom % 12) == 0;
      proc_strobe_n = ($urandom % 7) != 0;
      ctrl_strobe_n = ($urandom % 7) != 0;
      advance_n     = ($urandom % 3) == 0;
      wr_all_n      = ($urandom % 5) != 0;
      lane_wr_en_n  = ($urandom % 3) != 0;
      lane_sel_n    = 4'($urandom);
      din           = {4'($urandom), 32'($urandom)};
      out_en_n      = ($urandom % 9) == 0;
      sleep         = ($urandom % 20) == 0;
    end
    go(); quiet(); out_en_n = 1'b0; sleep = 1'b0;
    go();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule